// File: doc/BRIEF.md
# IDE PIO Strobe Timer

This block produces the active-low read and write strobes for one programmed-I/O data transfer on a disk interface. The host clock is the PCI clock. A transfer starts with a one-clock request. The request carries a direction, the drive's transfer mode and two 2-bit timing fields. The block lowers the strobe for the requested direction and counts the programmed active width. It then checks a synchronized copy of the drive's ready line. If the drive is not ready, the strobe stays low until it is. After that the block raises the strobe, waits out the recovery time and pulses `done`.

Drive modes 2 and above take their timing from the two fields. Modes 0 and 1 ignore the fields and use one fixed, slower compatible cycle. All request fields are captured when the transfer starts. Further requests are ignored until the transfer completes.

Top module: `ide_pio_strobe_timer`

## Requirements
- R1: While `rst` is high, and after it is released with no request, `dior_n` and `diow_n` are high and `done` is low.
- R2: When `req_write`=1 at start, only `diow_n` goes low. When `req_write`=0, only `dior_n` goes low. The two strobes are never low at the same time.
- R3: For `req_mode` >= 2 with `iordy` high, the strobe stays low for a number of clocks set by `req_smp`: 2'b00 gives 5, 2'b01 gives 4, 2'b10 gives 3 and 2'b11 gives 2. The first clock counted is the first clock the strobe is low.
- R4: For `req_mode` >= 2, after the strobe rises it stays high for a number of clocks set by `req_rcv`: 2'b00 gives 4, 2'b01 gives 3, 2'b10 gives 2 and 2'b11 gives 1. `done` is then raised.
- R5: For `req_mode` 0 or 1, the strobe is low for 6 clocks and high for 14 clocks before `done`, whatever the values of `req_smp` and `req_rcv`.
- R6: `iordy` passes through two flip-flops before it is used. Suppose `iordy` goes high during the k-th clock of strobe-low time. The strobe then stays low for the larger of the programmed width and k+2 clocks. While ready is seen low, the strobe stays low.
- R7: A request is accepted at a clock edge where `req_valid` is high and no transfer is in progress. Field changes and requests made during a transfer have no effect on that transfer and start no new one.
- R8: `done` is high for exactly one clock, the clock after the last recovery clock. Both strobes are high while `done` is high and stay high until the next request.
- R9: A request presented in the clock where `done` is high is accepted. Its strobe goes low on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start request, sampled while idle |
| req_write | input | 1 | 1 = write (uses `diow_n`), 0 = read (uses `dior_n`) |
| req_mode | input | 3 | Drive transfer mode |
| req_smp | input | 2 | Sample-point / active-width code |
| req_rcv | input | 2 | Recovery-width code |
| iordy | input | 1 | Drive ready, asynchronous |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest case to reach is the stretched strobe. The ready line has to change at a controlled point inside the strobe-low window, and the two synchronizer stages delay it before it is seen. The bench holds `iordy` low from before the request. It counts strobe-low clocks at falling edges and raises `iordy` in a chosen clock k. It then expects a low width of max(programmed, k+2). One case puts k early enough that the programmed width must still win. Other cases disturb the fields and hold `req_valid` high during a transfer, or place a new request exactly on the `done` clock.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_RCV  = 2'd2
  } pio_state_t;
endpackage

// File: rtl/ide_pio_sync.sv
module ide_pio_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= INIT;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ide_pio_timing_sel.sv
module ide_pio_timing_sel #(
  parameter int MODE_W      = 3,
  parameter int FIELD_W     = 2,
  parameter int CNT_W       = 4,
  parameter int PROG_MODE   = 2,
  parameter int COMPAT_ACT  = 6,
  parameter int COMPAT_RCV  = 14,
  parameter int MIN_ACT     = 2,
  parameter int MIN_RCV     = 1
) (
  input  logic [MODE_W-1:0]  mode,
  input  logic [FIELD_W-1:0] smp_code,
  input  logic [FIELD_W-1:0] rcv_code,
  output logic [CNT_W-1:0]   act_clks,
  output logic [CNT_W-1:0]   rcv_clks
);
  localparam int PAD = CNT_W - FIELD_W;

  logic prog;
  logic [CNT_W-1:0] smp_off, rcv_off;

  assign prog    = (int'(mode) >= PROG_MODE);
  assign smp_off = {{PAD{1'b0}}, ~smp_code};
  assign rcv_off = {{PAD{1'b0}}, ~rcv_code};

  always_comb begin
    if (prog) begin
      act_clks = CNT_W'(MIN_ACT) + smp_off;
      rcv_clks = CNT_W'(MIN_RCV) + rcv_off;
    end else begin
      act_clks = CNT_W'(COMPAT_ACT);
      rcv_clks = CNT_W'(COMPAT_RCV);
    end
  end
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wr,
  input  logic [CNT_W-1:0] act_clks,
  input  logic [CNT_W-1:0] rcv_clks,
  input  logic             rdy,
  output logic             dior_n,
  output logic             diow_n,
  output logic             done
);
  pio_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rcv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      rcv_q  <= '0;
      dior_n <= 1'b1;
      diow_n <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            rcv_q <= rcv_clks;
            cnt   <= act_clks - CNT_W'(1);
            state <= ST_ACT;
            if (wr) diow_n <= 1'b0;
            else    dior_n <= 1'b0;
          end
        end
        ST_ACT: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (rdy) begin
            dior_n <= 1'b1;
            diow_n <= 1'b1;
            cnt    <= rcv_q - CNT_W'(1);
            state  <= ST_RCV;
          end
        end
        ST_RCV: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ide_pio_strobe_timer.sv
module ide_pio_strobe_timer #(
  parameter int MODE_W     = 3,
  parameter int FIELD_W    = 2,
  parameter int SYNC_STG   = 2,
  parameter int COMPAT_ACT = 6,
  parameter int COMPAT_RCV = 14,
  localparam int CNT_W     = $clog2(COMPAT_RCV + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [MODE_W-1:0]  req_mode,
  input  logic [FIELD_W-1:0] req_smp,
  input  logic [FIELD_W-1:0] req_rcv,
  input  logic               iordy,
  output logic               dior_n,
  output logic               diow_n,
  output logic               done
);
  logic             rdy_s;
  logic [CNT_W-1:0] act_clks, rcv_clks;

  ide_pio_sync #(.STAGES(SYNC_STG), .INIT(1'b0)) u_sync (
    .clk(clk), .rst(rst), .d(iordy), .q(rdy_s)
  );

  ide_pio_timing_sel #(
    .MODE_W(MODE_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W),
    .COMPAT_ACT(COMPAT_ACT), .COMPAT_RCV(COMPAT_RCV)
  ) u_sel (
    .mode(req_mode), .smp_code(req_smp), .rcv_code(req_rcv),
    .act_clks(act_clks), .rcv_clks(rcv_clks)
  );

  ide_pio_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(req_valid), .wr(req_write),
    .act_clks(act_clks), .rcv_clks(rcv_clks), .rdy(rdy_s),
    .dior_n(dior_n), .diow_n(diow_n), .done(done)
  );
endmodule

// File: rtl/ide_pio_strobe_timer_chk.sv
module ide_pio_strobe_timer_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic dior_n,
  input logic diow_n,
  input logic done
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (!dior_n || !diow_n) low_cnt <= (low_cnt == 8'hFF) ? low_cnt : low_cnt + 8'd1;
    else low_cnt <= '0;
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (dior_n && diow_n));

  // R4
  recovery_seen_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(dior_n && diow_n));

  // R7
  start_from_req_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dior_n) || $fell(diow_n)) |-> $past(req_valid));

  // R3
  min_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dior_n && diow_n) |-> (low_cnt >= 8'd2));
endmodule

bind ide_pio_strobe_timer ide_pio_strobe_timer_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid),
  .dior_n(dior_n), .diow_n(diow_n), .done(done)
);

// File: tb/ide_pio_strobe_timer_bench.sv
module ide_pio_strobe_timer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [2:0] req_mode = 3'd0;
  logic [1:0] req_smp = 2'd0;
  logic [1:0] req_rcv = 2'd0;
  logic iordy = 1'b1;
  logic dior_n, diow_n, done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ide_pio_strobe_timer u_ide_pio_strobe_timer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mode(req_mode), .req_smp(req_smp), .req_rcv(req_rcv),
    .iordy(iordy), .dior_n(dior_n), .diow_n(diow_n), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One transfer; rise_at>0 raises iordy in that strobe-low clock.
  task automatic run_xfer(input logic wr, input logic [2:0] mode,
                          input logic [1:0] smp, input logic [1:0] rcv,
                          input int exp_act, input int exp_rcv,
                          input int rise_at, input bit disturb,
                          input string tag);
    int lows = 0, highs = 0, other = 0, idle_bad = 0;
    @(negedge clk);
    req_write = wr; req_mode = mode; req_smp = smp; req_rcv = rcv;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = disturb;
    for (int g = 0; g < 100; g++) begin
      if ((wr ? diow_n : dior_n) != 1'b0) break;
      lows++;
      if ((wr ? dior_n : diow_n) == 1'b0) other++;
      if (lows == rise_at) iordy = 1'b1;
      if (disturb) begin
        req_write = ~req_write; req_mode = ~req_mode;
        req_smp = ~req_smp; req_rcv = ~req_rcv;
      end
      @(negedge clk);
    end
    chk({tag, " strobe low clocks"}, lows, exp_act);
    chk("R2 opposite strobe low", other, 0);
    for (int g = 0; g < 100; g++) begin
      if (done) break;
      highs++;
      if (!dior_n || !diow_n) other++;
      if (disturb) begin req_smp = ~req_smp; req_rcv = ~req_rcv; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk({tag, " recovery clocks"}, highs, exp_rcv);
    chk("R8 strobes high with done", int'(dior_n && diow_n), 1);
    for (int g = 0; g < 5; g++) begin
      @(negedge clk);
      if (done || !dior_n || !diow_n) idle_bad++;
    end
    chk("R8/R7 single done then idle", idle_bad, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {dior_n, diow_n, done}, 3'b110);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 after reset", {dior_n, diow_n, done}, 3'b110);
  endtask

  task automatic t_prog_widths();
    run_xfer(1'b0, 3'd2, 2'b00, 2'b00, 5, 4, 0, 1'b0, "R3/R4 smp00 rcv00 read");
    run_xfer(1'b1, 3'd3, 2'b01, 2'b01, 4, 3, 0, 1'b0, "R3/R4 smp01 rcv01 write");
    run_xfer(1'b0, 3'd4, 2'b10, 2'b10, 3, 2, 0, 1'b0, "R3/R4 smp10 rcv10 read");
    run_xfer(1'b1, 3'd2, 2'b11, 2'b11, 2, 1, 0, 1'b0, "R3/R4 smp11 rcv11 write");
  endtask

  task automatic t_compat();
    run_xfer(1'b0, 3'd0, 2'b11, 2'b11, 6, 14, 0, 1'b0, "R5 mode0 read");
    run_xfer(1'b1, 3'd1, 2'b00, 2'b10, 6, 14, 0, 1'b0, "R5 mode1 write");
  endtask

  task automatic t_stretch();
    iordy = 1'b0; repeat (4) @(negedge clk);
    run_xfer(1'b1, 3'd2, 2'b11, 2'b11, 7, 1, 5, 1'b0, "R6 stretch k5 width2");
    iordy = 1'b0; repeat (4) @(negedge clk);
    run_xfer(1'b0, 3'd0, 2'b00, 2'b00, 8, 14, 6, 1'b0, "R6 stretch compat k6");
    iordy = 1'b0; repeat (4) @(negedge clk);
    run_xfer(1'b0, 3'd2, 2'b00, 2'b11, 5, 1, 1, 1'b0, "R6 early ready k1 width5");
  endtask

  task automatic t_latch();
    run_xfer(1'b0, 3'd2, 2'b01, 2'b10, 4, 2, 0, 1'b1, "R7 disturbed read");
    run_xfer(1'b1, 3'd0, 2'b01, 2'b10, 6, 14, 0, 1'b1, "R7 disturbed compat write");
  endtask

  task automatic t_back_to_back();
    int lows = 0;
    @(negedge clk);
    req_write = 1'b1; req_mode = 3'd2; req_smp = 2'b11; req_rcv = 2'b11;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int g = 0; g < 50; g++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R9 first done seen", int'(done), 1);
    req_write = 1'b0; req_smp = 2'b10; req_rcv = 2'b11; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 read strobe low after done clock", int'(dior_n), 0);
    for (int g = 0; g < 50; g++) begin
      if (dior_n) break;
      lows++;
      @(negedge clk);
    end
    chk("R9 second transfer width", lows, 3);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_prog_widths();
    t_compat();
    t_stretch();
    t_latch();
    t_back_to_back();
    summary();
    $finish;
  end
endmodule